// File: doc/BRIEF.md
# Page-Write Commit Engine

This block sits behind a two-wire serial slave in front of a byte-wide storage array. It gathers the data bytes of one write transfer in an eight-slot page buffer. Each slot has its own valid flag. On a Stop it copies the valid slots into the array and then holds a busy flag for a timed interval. The slave uses that flag to withhold acknowledges. Bus bit timing is not part of this block. The slave supplies a start-address strobe with the word address, a byte strobe with each data byte, and single-cycle Start and Stop events. It also supplies the write-protect level.

The word address splits into a page number (upper bits) and a slot offset (lower bits). Only the offset advances after each byte, and it wraps inside the page. A transfer longer than the page therefore overwrites its own earlier bytes, and a shorter one touches only the slots it filled. The commit is refused when write protect is high at the Stop. It is also dropped when the transfer is cut short by a repeated Start.

Control is a four-state machine:
- IDLE waits for an address.
- COLLECT fills the buffer.
- COMMIT scans the slots in offset order from zero, one per clock, and writes the valid ones.
- HOLD runs the busy timer.

The transitions are:
- IDLE→COLLECT on an address load.
- COLLECT→COLLECT on a new address load, which discards the buffered bytes.
- COLLECT→IDLE on a repeated Start, or on a Stop that cannot commit.
- COLLECT→COMMIT on a Stop with data buffered and protection low.
- COMMIT→HOLD after the last slot, with all valid flags cleared.
- HOLD→IDLE when the timer expires.

Top module: `cw_page_commit`

## Requirements
- R1: After reset `busy` and `mem_we` are low.
- R2: An address load sets the page to `start_addr[7:3]` and the slot offset to `start_addr[2:0]`. Each accepted byte is stored at the current offset, and then only the offset increments, wrapping from 7 to 0 inside the same page.
- R3: When more than 8 bytes are sent in one transfer, a later byte landing on a slot replaces the earlier one. Only the last value per slot is committed.
- R4: When fewer than 8 bytes are sent, only the array locations of the received slots change.
- R5: The Stop must find at least one buffered byte with `wp` low. `busy` then goes high in the cycle after the Stop is sampled, stays high for exactly `PAGE_BYTES + BUSY_CYCLES` cycles, and then falls.
- R6: During the commit, slots are visited in increasing offset order, one per clock. `mem_we` pulses only for valid slots, with `mem_addr = {page, slot}`, and only while `busy` is high.
- R7: If `wp` is high when the Stop is sampled, nothing is written to the array and `busy` stays low.
- R8: While `busy` is high, address loads, byte strobes, Start and Stop events are ignored. They change no array location and start no later commit.
- R9: A Start event during collection discards the buffered bytes, so a following Stop commits nothing and raises no busy.
- R10: All valid flags are clear when `busy` falls, so the next transfer commits only its own bytes.
- R11: A Stop with no byte buffered, or a Stop received in IDLE, writes nothing and raises no busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Strobe: `start_addr` holds the word address of a write transfer |
| start_addr | input | ADDR_W | Word address (page and slot offset) |
| byte_stb | input | 1 | Strobe: `byte_data` holds one received data byte |
| byte_data | input | DATA_W | Received data byte |
| start_evt | input | 1 | One-cycle pulse for a (repeated) Start on the bus |
| stop_evt | input | 1 | One-cycle pulse for a Stop on the bus |
| wp | input | 1 | Write-protect level, high protects the whole array |
| busy | output | 1 | Commit or timed hold in progress; the slave withholds acknowledges |
| mem_we | output | 1 | Array write enable, one byte per clock |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |

## Verification
The hardest conditions to reach from the ports are the wrap inside a page and input arriving during the busy interval. A wrap only shows when the start offset and the transfer length together cross the slot-7 boundary. Busy-time input only shows if stray traffic is injected at the right moment and its absence is then proven. The bench sweeps every start offset against lengths 1 to 10 on scattered pages, which covers partial, exact, wrapping and overwriting transfers. After each transfer it compares the whole array with an arithmetic model. During one busy interval it drives an address load, bytes, a Start and a Stop. Afterwards it issues a bare Stop and checks that no busy follows, which shows that nothing was latched.

// File: rtl/cw_pkg.sv
package cw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_COMMIT  = 2'd2,
        ST_HOLD    = 2'd3
    } cw_state_e;
endpackage

// File: rtl/cw_page_buf.sv
module cw_page_buf #(
    parameter int PAGE_BYTES = 8,
    parameter int DATA_W     = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    logic [DATA_W-1:0]     slot_data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] slot_vld;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_data[g] <= '0;
                slot_vld[g]  <= 1'b0;
            end else if (clr) begin
                slot_vld[g]  <= 1'b0;
            end else if (wr_en && (wr_idx == OFF_W'(g))) begin
                slot_data[g] <= wr_data;
                slot_vld[g]  <= 1'b1;
            end
        end
    end

    assign rd_data   = slot_data[rd_idx];
    assign rd_valid  = slot_vld[rd_idx];
    assign any_valid = |slot_vld;
endmodule

// File: rtl/cw_hold_timer.sv
module cw_hold_timer #(
    parameter int BUSY_CYCLES = 1000000,
    localparam int CNT_W      = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BUSY_CYCLES - 1);

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q) begin
            if (cnt_q == LAST_CNT) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign done = run_q && (cnt_q == LAST_CNT);
endmodule

// File: rtl/cw_page_commit.sv
module cw_page_commit
    import cw_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 8,
    parameter int BUSY_CYCLES = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              wp,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam logic [OFF_W-1:0] LAST_SLOT = OFF_W'(PAGE_BYTES - 1);

    cw_state_e         state_q, state_d;
    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  off_q;
    logic [OFF_W-1:0]  scan_q;

    logic              buf_clr, buf_wr, buf_vld, buf_any;
    logic [DATA_W-1:0] buf_rd;
    logic              hold_start, hold_done;
    logic              do_load;

    cw_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) buf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .wr_en     (buf_wr),
        .wr_idx    (off_q),
        .wr_data   (byte_data),
        .rd_idx    (scan_q),
        .rd_data   (buf_rd),
        .rd_valid  (buf_vld),
        .any_valid (buf_any)
    );

    cw_hold_timer #(.BUSY_CYCLES(BUSY_CYCLES)) tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (hold_start),
        .done  (hold_done)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (addr_load) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (stop_evt) begin
                    state_d = (buf_any && !wp) ? ST_COMMIT : ST_IDLE;
                end else if (start_evt) begin
                    state_d = ST_IDLE;
                end
            end
            ST_COMMIT: begin
                if (scan_q == LAST_SLOT) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (hold_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            page_q  <= '0;
            off_q   <= '0;
            scan_q  <= '0;
        end else begin
            state_q <= state_d;
            if (do_load) begin
                page_q <= start_addr[ADDR_W-1:OFF_W];
                off_q  <= start_addr[OFF_W-1:0];
            end else if (buf_wr) begin
                off_q  <= (off_q == LAST_SLOT) ? '0 : off_q + 1'b1;
            end
            if (state_q == ST_COMMIT) begin
                scan_q <= (scan_q == LAST_SLOT) ? '0 : scan_q + 1'b1;
            end else begin
                scan_q <= '0;
            end
        end
    end

    // outputs and strobes
    always_comb begin
        busy       = 1'b0;
        mem_we     = 1'b0;
        buf_clr    = 1'b0;
        buf_wr     = 1'b0;
        do_load    = 1'b0;
        hold_start = 1'b0;
        mem_addr   = {page_q, scan_q};
        mem_wdata  = buf_rd;
        unique case (state_q)
            ST_IDLE: begin
                if (addr_load) begin
                    do_load = 1'b1;
                    buf_clr = 1'b1;
                end
            end
            ST_COLLECT: begin
                if (stop_evt) begin
                    buf_clr = !(buf_any && !wp);
                end else if (start_evt) begin
                    buf_clr = 1'b1;
                end else if (addr_load) begin
                    do_load = 1'b1;
                    buf_clr = 1'b1;
                end else if (byte_stb) begin
                    buf_wr  = 1'b1;
                end
            end
            ST_COMMIT: begin
                busy   = 1'b1;
                mem_we = buf_vld;
                if (scan_q == LAST_SLOT) begin
                    buf_clr    = 1'b1;
                    hold_start = 1'b1;
                end
            end
            ST_HOLD: begin
                busy = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cw_page_commit_chk.sv
module cw_page_commit_chk #(
    parameter int ADDR_W = 8,
    parameter int OFF_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_evt,
    input logic              wp,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              any_valid
);
    // R6: array writes only inside the busy window
    p_we_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R5: a committable Stop raises busy next cycle
    p_busy_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !busy && !wp && any_valid) |=> busy);

    // R7: protected Stop never raises busy from idle
    p_wp_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !busy && wp) |=> !busy);

    // R2: consecutive commit writes stay inside one page
    p_page_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W])));

    // R10: buffer empty when busy ends
    p_clean_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !any_valid);
endmodule

bind cw_page_commit cw_page_commit_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_evt  (stop_evt),
    .wp        (wp),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .any_valid (buf_any)
);

// File: tb/cw_page_commit_tb_top.sv
`timescale 1ns/1ps
module cw_page_commit_tb_top;
    localparam int BC = 20;
    localparam int PB = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_load = 1'b0;
    logic [7:0] start_addr = '0;
    logic       byte_stb = 1'b0;
    logic [7:0] byte_data = '0;
    logic       start_evt = 1'b0;
    logic       stop_evt = 1'b0;
    logic       wp = 1'b0;
    logic       busy, mem_we;
    logic [7:0] mem_addr, mem_wdata;

    always #2.5 clk = ~clk;

    cw_page_commit #(.ADDR_W(8), .DATA_W(8), .PAGE_BYTES(PB), .BUSY_CYCLES(BC)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .start_addr(start_addr),
        .byte_stb(byte_stb), .byte_data(byte_data), .start_evt(start_evt),
        .stop_evt(stop_evt), .wp(wp), .busy(busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    logic [7:0] mem   [256];
    logic [7:0] exp_m [256];
    int         writes;
    logic       cnt_clr = 1'b0;
    logic       ord_err;
    logic [2:0] last_slot;
    int         vectors = 0;
    int         miscompares = 0;
    bit         finished = 0;

    always @(posedge clk) begin
        if (cnt_clr) begin
            writes  <= 0;
            ord_err <= 1'b0;
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            writes        <= writes + 1;
            if (writes != 0 && mem_addr[2:0] <= last_slot) ord_err <= 1'b1;
            last_slot     <= mem_addr[2:0];
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic do_load(input logic [7:0] a);
        addr_load = 1'b1; start_addr = a; tick(); addr_load = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] d);
        byte_stb = 1'b1; byte_data = d; tick(); byte_stb = 1'b0;
    endtask

    task automatic do_stop(input logic w);
        stop_evt = 1'b1; wp = w; tick(); stop_evt = 1'b0; wp = 1'b0;
    endtask

    task automatic do_start;
        start_evt = 1'b1; tick(); start_evt = 1'b0;
    endtask

    task automatic clr_cnt;
        cnt_clr = 1'b1; tick(); cnt_clr = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 5000) begin
            n++;
            tick();
        end
    endtask

    task automatic chk_mem(input string tag);
        int bad;
        bad = -1;
        for (int a = 255; a >= 0; a--) if (mem[a] !== exp_m[a]) bad = a;
        if (bad < 0) chk(1'b1, tag, 0, 0);
        else chk(1'b0, tag, int'(mem[bad]), int'(exp_m[bad]));
    endtask

    initial begin
        int n;
        for (int a = 0; a < 256; a++) begin
            mem[a]   = 8'(a ^ 8'h5A);
            exp_m[a] = 8'(a ^ 8'h5A);
        end
        writes = 0; ord_err = 1'b0; last_slot = '0;
        repeat (3) tick();
        chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        chk(mem_we == 1'b0, "R1 mem_we after reset", int'(mem_we), 0);
        rst_n = 1'b1;
        tick();

        // sweep: every start offset x lengths 1..10
        for (int k = 0; k < 80; k++) begin
            int so, len, pg;
            string tag;
            so  = k % PB;
            len = 1 + k / PB;
            pg  = (k * 7 + 3) % 32;
            tag = (len > PB) ? "R3 overwrite" : ((len < PB) ? "R4 partial" : "R2 full page");
            do_load(8'(pg * PB + so));
            for (int i = 0; i < len; i++) begin
                logic [7:0] d;
                d = 8'((k * 13 + i * 29 + 5) & 255);
                do_byte(d);
                exp_m[pg * PB + ((so + i) % PB)] = d;
            end
            clr_cnt();
            do_stop(1'b0);
            chk(busy == 1'b1, "R5 busy rises", int'(busy), 1);
            wait_idle(n);
            chk(n == PB + BC, "R5 busy length", n, PB + BC);
            chk(writes == ((len > PB) ? PB : len), "R6 write count", writes, (len > PB) ? PB : len);
            chk(ord_err == 1'b0, "R6 slot order", int'(ord_err), 0);
            chk_mem(tag);
        end

        // R7: write protect at Stop
        do_load(8'h40);
        do_byte(8'hAA); do_byte(8'hBB); do_byte(8'hCC);
        clr_cnt();
        do_stop(1'b1);
        chk(busy == 1'b0, "R7 no busy under wp", int'(busy), 0);
        repeat (PB + 2) tick();
        chk(writes == 0, "R7 no writes under wp", writes, 0);
        chk_mem("R7 array unchanged");

        // R9: repeated Start discards bytes
        do_load(8'h81);
        do_byte(8'h11); do_byte(8'h22);
        do_start();
        clr_cnt();
        do_stop(1'b0);
        chk(busy == 1'b0, "R9 no busy after restart", int'(busy), 0);
        repeat (PB + 2) tick();
        chk(writes == 0, "R9 no writes after restart", writes, 0);

        // R11: Stop with empty buffer, and Stop in idle
        do_load(8'h90);
        do_stop(1'b0);
        chk(busy == 1'b0, "R11 empty stop", int'(busy), 0);
        do_stop(1'b0);
        chk(busy == 1'b0, "R11 idle stop", int'(busy), 0);
        repeat (PB + 2) tick();
        chk(writes == 0, "R11 no writes", writes, 0);

        // R8: traffic during busy is ignored
        do_load(8'h23);
        do_byte(8'h77);
        exp_m[8'h23] = 8'h77;
        clr_cnt();
        do_stop(1'b0);
        tick();
        do_load(8'hF0);
        do_byte(8'hE1); do_byte(8'hE2);
        do_start();
        do_byte(8'hE3);
        do_stop(1'b0);
        wait_idle(n);
        chk(writes == 1, "R8 only pre-busy byte written", writes, 1);
        chk_mem("R8 array after busy traffic");
        clr_cnt();
        do_stop(1'b0);
        chk(busy == 1'b0, "R8 nothing latched during busy", int'(busy), 0);
        repeat (PB + 2) tick();
        chk(writes == 0, "R8 no late commit", writes, 0);

        // R10: next transfer commits only its own byte
        do_load(8'hC8);
        do_byte(8'h3C);
        exp_m[8'hCA - 2] = 8'h3C;
        clr_cnt();
        do_stop(1'b0);
        wait_idle(n);
        chk(writes == 1, "R10 single byte commit", writes, 1);
        chk_mem("R10 array");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule